// File: doc/BRIEF.md
# Station Address Match Filter

This block decides whether a received frame is addressed to this station. The destination address arrives one byte per cycle, first byte first. Once the sixth byte has arrived, the block checks it against three receive modes and against a 16-entry table of station addresses. It reports accept or reject, together with a status word. That word carries a multicast flag or a broadcast flag when one of those modes caused the acceptance.

The address table is filled by a loader that reads from memory. The host starts the loader with a pointer and a descriptor count. The loader reads each descriptor in turn and writes the address it holds into the next table entry. After the last descriptor it reads one more field, and that field becomes the per-entry enable mask. While the controller is held in reset mode, the host can read any table entry back through three 16-bit ports.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, `flt_done`, `flt_accept`, `flt_flags`, `load_busy`, `load_done`, `mem_rd_req` and `cam_enable` are all 0, and every table entry holds 0.
- R2: With `cfg_promisc` set and the group bit clear, the frame is accepted with status flags 0. The group bit is bit 0 of the first byte.
- R3: With `cfg_all_mcast` set and the group bit set, the frame is accepted with the multicast flag, `flt_flags` = 16'h0100. R2 takes precedence over this rule.
- R4: With `cfg_bcast` set and all six bytes equal to 8'hFF, the frame is accepted with the broadcast flag, `flt_flags` = 16'h0080. R2 and R3 take precedence over this rule.
- R5: If none of R2, R3 or R4 applies, the frame is accepted with flags 0 when it exactly equals an entry whose bit in `cam_enable` is 1. Entries whose enable bit is 0 never match.
- R6: The priority holds for combined modes. `cfg_promisc` does not accept a group address. An all-FF address with both `cfg_all_mcast` and `cfg_bcast` set reports only the multicast flag.
- R7: A frame that meets none of the rules gives `flt_accept` = 0 and `flt_flags` = 0.
- R8: `flt_done` pulses for one cycle, exactly one cycle after the cycle in which the sixth byte is valid. A byte marked with `rx_sof` always counts as byte 0.
- R9: The loader starts on `load_start` and repeats while the count (bits 4:0 of `load_count`) is nonzero. Each descriptor is four fields. Field k (k = 1, 2, 3) holds address bytes 2k-2 in bits 7:0 and 2k-1 in bits 15:8, and goes into the next entry, starting at entry 0. After each descriptor, the pointer advances by one descriptor and the count drops by one.
- R10: After the last descriptor, the loader reads field 0 at the current pointer into `cam_enable`. `cam_enable` changes at no other time.
- R11: At the end of a load, `load_busy` falls and `load_done` pulses for exactly one cycle.
- R12: With `cfg_wide` = 0, a field is 2 bytes and a descriptor 8 bytes. With `cfg_wide` = 1, a field is 4 bytes and a descriptor 16 bytes, and only bits 15:0 of the read data are used.
- R13: While `in_reset` = 1, `rb_lo`, `rb_mid` and `rb_hi` give bytes {1,0}, {3,2} and {5,4} of entry `rb_sel`, with the higher-numbered byte in bits 15:8. While `in_reset` = 0, all three ports read 0.
- R14: A load with count 0 reads only the enable mask at the starting pointer and leaves every table entry unchanged. Count bits above bit 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_promisc | input | 1 | Accept every individual (non-group) address |
| cfg_all_mcast | input | 1 | Accept every group address |
| cfg_bcast | input | 1 | Accept the all-ones address |
| cfg_wide | input | 1 | Memory fields are 32 bits wide |
| rx_valid | input | 1 | Destination byte valid |
| rx_sof | input | 1 | This byte is byte 0 of a new address |
| rx_byte | input | 8 | Destination address byte |
| flt_done | output | 1 | Decision valid, one-cycle pulse |
| flt_accept | output | 1 | Frame accepted |
| flt_flags | output | 16 | Receive status flags (bit 8 multicast, bit 7 broadcast) |
| load_start | input | 1 | Start a table load |
| load_ptr | input | PTR_W | Memory address of the first descriptor |
| load_count | input | 16 | Descriptor count; bits 4:0 used |
| load_busy | output | 1 | Table load in progress |
| load_done | output | 1 | Table load finished, one-cycle pulse |
| mem_rd_req | output | 1 | Read request, held until acknowledged |
| mem_rd_addr | output | PTR_W | Byte address of the requested field |
| mem_rd_ack | input | 1 | Read data valid for the held request |
| mem_rd_data | input | 32 | Read data |
| cam_enable | output | ENTRIES | Per-entry enable mask |
| in_reset | input | 1 | Controller is in reset mode; enables read-back |
| rb_sel | input | IDX_W | Entry selected for read-back |
| rb_lo | output | 16 | Bytes 1:0 of the selected entry |
| rb_mid | output | 16 | Bytes 3:2 of the selected entry |
| rb_hi | output | 16 | Bytes 5:4 of the selected entry |

## Verification
A filter decision is due on the cycle after the sixth byte. The bench records the cycle in which it drives that byte. It pushes the expected decision together with a due cycle one later, and the monitor checks the cycle number on every pop. The `load_done` pulse comes one cycle after the mask read is acknowledged. The bench therefore waits until `load_busy` falls and then counts the pulses over the following edge. The read-back ports are combinational, so they are sampled one falling edge after `rb_sel` or `in_reset` changes.

// File: rtl/dest_addr_filter.sv
module dest_addr_filter #(
  parameter int ENTRIES = 16,
  parameter int PTR_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_promisc,
  input  logic               cfg_all_mcast,
  input  logic               cfg_bcast,
  input  logic               cfg_wide,
  input  logic               rx_valid,
  input  logic               rx_sof,
  input  logic [7:0]         rx_byte,
  output logic               flt_done,
  output logic               flt_accept,
  output logic [15:0]        flt_flags,
  input  logic               load_start,
  input  logic [PTR_W-1:0]   load_ptr,
  input  logic [15:0]        load_count,
  output logic               load_busy,
  output logic               load_done,
  output logic               mem_rd_req,
  output logic [PTR_W-1:0]   mem_rd_addr,
  input  logic               mem_rd_ack,
  input  logic [31:0]        mem_rd_data,
  output logic [ENTRIES-1:0] cam_enable,
  input  logic               in_reset,
  input  logic [IDX_W-1:0]   rb_sel,
  output logic [15:0]        rb_lo,
  output logic [15:0]        rb_mid,
  output logic [15:0]        rb_hi
);
  localparam logic [15:0] FLAG_MC = 16'h0100;
  localparam logic [15:0] FLAG_BC = 16'h0080;

  typedef enum logic [1:0] {LD_IDLE, LD_ENT, LD_MASK} ld_st_t;

  logic [47:0]      cam_q [ENTRIES];
  ld_st_t           ld_st;
  logic [PTR_W-1:0] ld_ptr;
  logic [4:0]       ld_cnt;
  logic [IDX_W-1:0] ld_idx;
  logic [1:0]       ld_fld;
  logic [2:0]       bcnt;
  logic [39:0]      head;
  logic [ENTRIES-1:0] hit;

  wire [2:0]  pos  = rx_sof ? 3'd0 : bcnt;
  wire        last = rx_valid && (pos == 3'd5);
  wire [47:0] dest = {rx_byte, head};
  wire        grp  = dest[0];
  wire        take_uni = cfg_promisc && !grp;
  wire        take_mc  = cfg_all_mcast && grp;
  wire        take_bc  = cfg_bcast && (&dest);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign hit[i] = cam_enable[i] && (cam_q[i] == dest);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt       <= '0;
      head       <= '0;
      flt_done   <= 1'b0;
      flt_accept <= 1'b0;
      flt_flags  <= '0;
    end else begin
      flt_done <= last;
      if (last) begin
        flt_accept <= take_uni || take_mc || take_bc || (|hit);
        flt_flags  <= take_uni ? 16'h0000 : take_mc ? FLAG_MC : take_bc ? FLAG_BC : 16'h0000;
      end
      if (rx_valid) begin
        if (pos == 3'd5) bcnt <= '0;
        else begin
          head[8*pos +: 8] <= rx_byte;
          bcnt <= pos + 3'd1;
        end
      end
    end
  end

  wire [PTR_W-1:0] fld_off = cfg_wide ? PTR_W'({ld_fld, 2'b00}) : PTR_W'({ld_fld, 1'b0});
  wire [PTR_W-1:0] step    = cfg_wide ? PTR_W'(16) : PTR_W'(8);

  assign load_busy   = (ld_st != LD_IDLE);
  assign mem_rd_req  = load_busy;
  assign mem_rd_addr = (ld_st == LD_ENT) ? ld_ptr + fld_off : ld_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_st      <= LD_IDLE;
      ld_ptr     <= '0;
      ld_cnt     <= '0;
      ld_idx     <= '0;
      ld_fld     <= 2'd1;
      cam_enable <= '0;
      load_done  <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) cam_q[i] <= '0;
    end else begin
      load_done <= 1'b0;
      case (ld_st)
        LD_IDLE: if (load_start) begin
          ld_ptr <= load_ptr;
          ld_cnt <= load_count[4:0];
          ld_idx <= '0;
          ld_fld <= 2'd1;
          ld_st  <= (load_count[4:0] != 5'd0) ? LD_ENT : LD_MASK;
        end
        LD_ENT: if (mem_rd_ack) begin
          case (ld_fld)
            2'd1:    cam_q[ld_idx][15:0]  <= mem_rd_data[15:0];
            2'd2:    cam_q[ld_idx][31:16] <= mem_rd_data[15:0];
            default: cam_q[ld_idx][47:32] <= mem_rd_data[15:0];
          endcase
          if (ld_fld == 2'd3) begin
            ld_fld <= 2'd1;
            ld_idx <= ld_idx + 1'b1;
            ld_cnt <= ld_cnt - 5'd1;
            ld_ptr <= ld_ptr + step;
            if (ld_cnt == 5'd1) ld_st <= LD_MASK;
          end else begin
            ld_fld <= ld_fld + 2'd1;
          end
        end
        LD_MASK: if (mem_rd_ack) begin
          cam_enable <= mem_rd_data[ENTRIES-1:0];
          ld_st      <= LD_IDLE;
          load_done  <= 1'b1;
        end
        default: ld_st <= LD_IDLE;
      endcase
    end
  end

  wire [47:0] rb_ent = cam_q[rb_sel];
  assign rb_lo  = in_reset ? rb_ent[15:0]  : 16'h0000;
  assign rb_mid = in_reset ? rb_ent[31:16] : 16'h0000;
  assign rb_hi  = in_reset ? rb_ent[47:32] : 16'h0000;

  p_done_after_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flt_done |-> $past(rx_valid));
  p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_done |-> !(flt_flags[8] && flt_flags[7]));
  p_flag_needs_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_done && (|flt_flags)) |-> flt_accept);
  p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));
  p_mask_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_busy && !load_start) |=> $stable(cam_enable));
  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> (!load_busy && $past(load_busy)));
  p_load_between_frames_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_start |-> (bcnt == 3'd0));
endmodule

// File: tb/dest_addr_filter_bench.sv
module dest_addr_filter_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_promisc = 0, cfg_all_mcast = 0, cfg_bcast = 0, cfg_wide = 0;
  logic rx_valid = 0, rx_sof = 0;
  logic [7:0] rx_byte = '0;
  logic flt_done, flt_accept;
  logic [15:0] flt_flags;
  logic load_start = 0;
  logic [31:0] load_ptr = '0;
  logic [15:0] load_count = '0;
  logic load_busy, load_done, mem_rd_req, mem_rd_ack = 0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0;
  logic [15:0] cam_enable;
  logic in_reset = 1'b1;
  logic [3:0] rb_sel = '0;
  logic [15:0] rb_lo, rb_mid, rb_hi;

  dest_addr_filter u_dest_addr_filter (
    .clk(clk), .rst_n(rst_n), .cfg_promisc(cfg_promisc), .cfg_all_mcast(cfg_all_mcast),
    .cfg_bcast(cfg_bcast), .cfg_wide(cfg_wide), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_byte(rx_byte), .flt_done(flt_done), .flt_accept(flt_accept), .flt_flags(flt_flags),
    .load_start(load_start), .load_ptr(load_ptr), .load_count(load_count),
    .load_busy(load_busy), .load_done(load_done), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
    .cam_enable(cam_enable), .in_reset(in_reset), .rb_sel(rb_sel),
    .rb_lo(rb_lo), .rb_mid(rb_mid), .rb_hi(rb_hi));

  int checks = 0, fails = 0, cyc = 0, done_pulses = 0;
  logic [15:0] mem [256];
  logic [47:0] bcam [16];
  logic [15:0] bmask = '0;
  logic [16:0] res_q [$];
  int due_q [$];

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (load_done) done_pulses++;

  always @(negedge clk) begin
    if (mem_rd_req && !mem_rd_ack) begin
      mem_rd_ack  = 1'b1;
      mem_rd_data = {16'hBEEF, mem[mem_rd_addr[8:1]]};
    end else mem_rd_ack = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && flt_done) begin
      if (res_q.size() == 0) chk(0, "R8 unexpected decision", 64'(flt_accept), 64'h0);
      else begin
        logic [16:0] e;
        int d;
        e = res_q.pop_front();
        d = due_q.pop_front();
        chk(cyc == d, "R8 decision cycle", 64'(cyc), 64'(d));
        chk({flt_accept, flt_flags} == e, "R2-R7 decision", 64'({flt_accept, flt_flags}), 64'(e));
      end
    end
  end

  function automatic logic [16:0] model(input logic [47:0] a, input logic p, m, b);
    if (p && !a[0]) return {1'b1, 16'h0000};
    if (m && a[0]) return {1'b1, 16'h0100};
    if (b && (&a)) return {1'b1, 16'h0080};
    for (int i = 0; i < 16; i++) if (bmask[i] && bcam[i] == a) return {1'b1, 16'h0000};
    return 17'h0;
  endfunction

  task automatic send(input logic [47:0] a, input logic p, m, b);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (n == 0) begin cfg_promisc = p; cfg_all_mcast = m; cfg_bcast = b; end
      rx_valid = 1'b1;
      rx_sof   = (n == 0);
      rx_byte  = a[8*n +: 8];
      if (n == 5) begin
        res_q.push_back(model(a, p, m, b));
        due_q.push_back(cyc + 1);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_valid = 1'b0;
      rx_sof = 1'b0;
    end
  endtask

  task automatic put_desc(input int base, input int i, input logic [47:0] a, input logic wide);
    for (int k = 1; k <= 3; k++) begin
      int adr;
      adr = base + i * (wide ? 16 : 8) + k * (wide ? 4 : 2);
      mem[adr >> 1] = a[16*(k-1) +: 16];
    end
  endtask

  task automatic run_load(input int ptr, input logic [15:0] cnt, input logic wide);
    @(negedge clk);
    cfg_wide = wide;
    load_ptr = ptr;
    load_count = cnt;
    load_start = 1'b1;
    done_pulses = 0;
    @(negedge clk);
    load_start = 1'b0;
    while (load_busy) @(negedge clk);
    @(negedge clk);
    chk(done_pulses == 1, "R11 load_done pulses", 64'(done_pulses), 64'd1);
    chk(!load_busy, "R11 busy cleared", 64'(load_busy), 64'd0);
  endtask

  task automatic rb_check(input int e, input logic [47:0] a, input string req);
    @(negedge clk);
    rb_sel = e[3:0];
    in_reset = 1'b1;
    @(negedge clk);
    chk({rb_hi, rb_mid, rb_lo} == a, req, 64'({rb_hi, rb_mid, rb_lo}), 64'(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  localparam logic [47:0] A0 = 48'h01_00_00_00_00_02;
  localparam logic [47:0] A1 = 48'h02_00_00_00_00_02;
  localparam logic [47:0] A2 = 48'h07_00_00_5E_00_01;
  localparam logic [47:0] B0 = 48'h66_55_44_33_22_10;
  localparam logic [47:0] B1 = 48'hCC_BB_AA_99_88_76;
  localparam logic [47:0] UNI = 48'h11_22_33_44_55_0A;
  localparam logic [47:0] GRP = 48'h00_00_00_00_00_33;
  localparam logic [47:0] BCST = 48'hFF_FF_FF_FF_FF_FF;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hA5A5;
    for (int i = 0; i < 16; i++) bcam[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!flt_done && !flt_accept && flt_flags == 0, "R1 filter outputs", 64'({flt_done, flt_accept, flt_flags}), 64'd0);
    chk(!load_busy && !load_done && !mem_rd_req, "R1 loader idle", 64'({load_busy, load_done, mem_rd_req}), 64'd0);
    chk(cam_enable == 0, "R1 enable mask", 64'(cam_enable), 64'd0);
    rb_check(5, 48'h0, "R1 entry cleared");

    // R9 R10: 16-bit fields, three descriptors at 0x40, mask at 0x58
    put_desc(32'h40, 0, A0, 0);
    put_desc(32'h40, 1, A1, 0);
    put_desc(32'h40, 2, A2, 0);
    mem[32'h58 >> 1] = 16'h0005;
    run_load(32'h40, 16'd3, 1'b0);
    bcam[0] = A0; bcam[1] = A1; bcam[2] = A2; bmask = 16'h0005;
    chk(cam_enable == 16'h0005, "R10 mask after load", 64'(cam_enable), 64'h5);
    rb_check(0, A0, "R9 entry 0");
    rb_check(1, A1, "R9 entry 1");
    rb_check(2, A2, "R13 entry 2 ports");
    @(negedge clk);
    in_reset = 1'b0;
    @(negedge clk);
    chk({rb_hi, rb_mid, rb_lo} == 0, "R13 ports zero outside reset", 64'({rb_hi, rb_mid, rb_lo}), 64'd0);

    // filter patterns
    send(A0, 0, 0, 0);        // R5 enabled entry
    send(A1, 0, 0, 0);        // R5 disabled entry rejects
    send(A2, 0, 0, 0);        // R5 group address in table
    send(UNI, 0, 0, 0);       // R7
    send(UNI, 1, 0, 0);       // R2
    send(GRP, 1, 0, 0);       // R6 promisc ignores group
    send(GRP, 0, 1, 0);       // R3
    send(BCST, 0, 0, 1);      // R4
    send(BCST, 0, 1, 1);      // R6 multicast wins
    send(BCST, 0, 0, 0);      // R7
    idle(2);
    // R8: partial address then resync on rx_sof
    for (int n = 0; n < 3; n++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (n == 0); rx_byte = 8'h5A;
    end
    send(A0, 0, 0, 0);
    idle(4);
    chk(res_q.size() == 0, "R8 all decisions seen", 64'(res_q.size()), 64'd0);

    // R12: 32-bit fields, two descriptors at 0x80, mask at 0xA0
    put_desc(32'h80, 0, B0, 1);
    put_desc(32'h80, 1, B1, 1);
    mem[32'hA0 >> 1] = 16'h0003;
    run_load(32'h80, 16'd2, 1'b1);
    bcam[0] = B0; bcam[1] = B1; bmask = 16'h0003;
    chk(cam_enable == 16'h0003, "R12 mask in wide mode", 64'(cam_enable), 64'h3);
    rb_check(1, B1, "R12 entry 1 wide");
    rb_check(2, A2, "R12 entry 2 untouched");
    @(negedge clk);
    in_reset = 1'b0;
    send(B1, 0, 0, 0);        // R5
    send(A0, 0, 0, 0);        // R7 overwritten
    send(A2, 0, 0, 0);        // R5 disabled by mask
    idle(4);

    // R14: count bits above 4 ignored, only mask is read
    mem[32'hC0 >> 1] = 16'h8000;
    run_load(32'hC0, 16'h0020, 1'b0);
    bmask = 16'h8000;
    chk(cam_enable == 16'h8000, "R14 mask only", 64'(cam_enable), 64'h8000);
    rb_check(0, B0, "R14 entry 0 kept");
    @(negedge clk);
    in_reset = 1'b0;
    send(B0, 0, 0, 0);        // R14 entry now disabled
    idle(4);
    chk(res_q.size() == 0, "R8 queue drained", 64'(res_q.size()), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule